// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block connects a synchronous request/acknowledge host port to an external asynchronous static RAM of 131,072 bytes. The host presents a 17-bit byte address, a read/write flag and write data. The block drives the memory's two selects (one active-low, one active-high), its output and write enables, the address bus and a shared tri-state data bus. It stretches every access over enough clock cycles to meet the memory's nanosecond limits. It then returns an acknowledge and, for reads, the captured byte.

All limits are converted to clock cycles at elaboration as N(t) = max(1, ceil(t / CLK_NS)). The read limits come from a table indexed by the speed grade (55, 70, 85 or 100 ns), and the write pulse and hold times are plain parameters. Every memory-side pin is taken straight from a flip-flop. A low-power input holds the device deselected, and after it is released the block waits out a recovery interval before the next access starts.

Top module: `sram_link`

## Requirements
- R1: While rstN is low and in the first cycle after it, memSelN=1, memSelHi=0, memOutEnN=1, memWrEnN=1, ack=0 and rdata=0.
- R2: In every cycle with no access in progress (including the acknowledge cycle), the device is deselected (memSelN=1, memSelHi=0) with memOutEnN=1 and memWrEnN=1.
- R3: memAddr shows the accepted request's address in every cycle of its access and does not change while the device is selected.
- R4: A read selects the device for N_ACC cycles with memWrEnN=1, and memOutEnN is low only in the final N_OE of those cycles. With the defaults (55 ns grade, 5 ns clock, 35 ns output-enable access) this is 11 and 7 cycles.
- R5: At the edge ending a read's last cycle, rdata takes the value on memData. ack is high for exactly the next cycle, and rdata then holds until the next read completes.
- R6: A write selects the device with memWrEnN low for N_WE cycles (11 by default), then memWrEnN high with the device still selected for N_WH cycles (1 by default), and then gives a one-cycle ack.
- R7: The block drives memData with the request's write data in every cycle of a write (both phases) and never while memOutEnN is low.
- R8: The first cycle of a write comes no earlier than after N_TURN+1 deselected cycles following a read's last cycle, counting the acknowledge cycle. N_TURN is the larger of the chip-disable and output-disable float times in cycles, 5 by default.
- R9: A request is accepted only with no access in progress and never in the acknowledge cycle. While lowPower is sampled high, no access starts and the device stays deselected. After lowPower is sampled low, the earliest start is the (N_REC+1)-th such rising edge, with N_REC = N_ACC (12th by default).
- R10: Reading an address returns the byte most recently written to it, for any data pattern and at both ends of the address range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request pending; held until ack |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Byte address |
| reqWdata | input | 8 | Write data |
| lowPower | input | 1 | Hold the memory in standby |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last byte read |
| memAddr | output | 17 | Memory address bus |
| memSelN | output | 1 | Active-low memory select |
| memSelHi | output | 1 | Active-high memory select |
| memOutEnN | output | 1 | Active-low memory output enable |
| memWrEnN | output | 1 | Active-low memory write enable |
| memData | inout | 8 | Shared tri-state data bus |

## Verification
The hardest situations to reach are a write requested while the bus is still floating after a read, and a request that is already pending when the low-power hold is released. The stimulus reaches the first by issuing a write in the cycle right after a read's acknowledge, with the request held through the turnaround wait. It reaches the second by raising a request while lowPower is high and dropping lowPower later. A behavioural model in the bench predicts every pin in every cycle. A memory model on the bus checks the bytes that come back.

// File: rtl/sram_link_pkg.sv
`timescale 1ns/1ps
package sram_link_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_READ   = 2'd1,
    ST_WPULSE = 2'd2,
    ST_WHOLD  = 2'd3
  } linkState_t;

  // load/capture act in the current cycle; sel/oe/we/drive are the
  // pin values for the next cycle and are registered in the datapath.
  typedef struct packed {
    logic load;
    logic capture;
    logic sel;
    logic oe;
    logic we;
    logic drive;
  } strobe_t;

  function automatic int ceilCycles(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int gradeOeNs(input int grade);
    case (grade)
      55:      return 35;
      70:      return 40;
      85:      return 40;
      default: return 50;
    endcase
  endfunction

  function automatic int gradeSelFloatNs(input int grade);
    case (grade)
      55:      return 25;
      70:      return 30;
      85:      return 35;
      default: return 40;
    endcase
  endfunction

  function automatic int gradeOeFloatNs(input int grade);
    case (grade)
      55:      return 25;
      70:      return 25;
      85:      return 30;
      default: return 35;
    endcase
  endfunction

endpackage

// File: rtl/sram_link_ctrl.sv
`timescale 1ns/1ps
module sram_link_ctrl
  import sram_link_pkg::*;
#(
  parameter int ACC_CYC  = 11,
  parameter int OE_CYC   = 7,
  parameter int TURN_CYC = 5,
  parameter int WE_CYC   = 11,
  parameter int WH_CYC   = 1,
  parameter int REC_CYC  = 11
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    lowPower,
  output logic    ack,
  output strobe_t strb
);

  localparam int MAX_A   = (ACC_CYC > WE_CYC) ? ACC_CYC : WE_CYC;
  localparam int MAX_B   = (WH_CYC > TURN_CYC) ? WH_CYC : TURN_CYC;
  localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CYC = (MAX_C > REC_CYC) ? MAX_C : REC_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int OE_FROM = ACC_CYC - OE_CYC;

  linkState_t       state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic [CNT_W-1:0] recCnt, hizCnt;
  logic             ackNext, accept, capture;

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    ackNext   = 1'b0;
    accept    = 1'b0;
    capture   = 1'b0;
    case (state)
      ST_IDLE: begin
        accept = reqValid && !lowPower && (recCnt == '0) && !ack &&
                 (!reqWrite || (hizCnt == '0));
        if (accept) begin
          stateNext = reqWrite ? ST_WPULSE : ST_READ;
          cntNext   = '0;
        end
      end
      ST_READ: begin
        if (cnt == CNT_W'(ACC_CYC - 1)) begin
          stateNext = ST_IDLE;
          ackNext   = 1'b1;
          capture   = 1'b1;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      ST_WPULSE: begin
        if (cnt == CNT_W'(WE_CYC - 1)) begin
          stateNext = ST_WHOLD;
          cntNext   = '0;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      ST_WHOLD: begin
        if (cnt == CNT_W'(WH_CYC - 1)) begin
          stateNext = ST_IDLE;
          ackNext   = 1'b1;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strb.load    = accept;
    strb.capture = capture;
    strb.sel     = (stateNext != ST_IDLE);
    strb.oe      = (stateNext == ST_READ) && (cntNext >= CNT_W'(OE_FROM));
    strb.we      = (stateNext == ST_WPULSE);
    strb.drive   = (stateNext == ST_WPULSE) || (stateNext == ST_WHOLD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      ack    <= 1'b0;
      recCnt <= '0;
      hizCnt <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
      ack   <= ackNext;
      if (state == ST_IDLE) begin
        if (lowPower)            recCnt <= CNT_W'(REC_CYC);
        else if (recCnt != '0)   recCnt <= recCnt - 1'b1;
        if (hizCnt != '0)        hizCnt <= hizCnt - 1'b1;
      end else if (capture) begin
        hizCnt <= CNT_W'(TURN_CYC);
      end
    end
  end

  // Checker-only count of cycles since the bus was last read.
  int sinceRd;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     sinceRd <= TURN_CYC + 1;
    else if (state == ST_READ)     sinceRd <= 0;
    else if (sinceRd <= TURN_CYC)  sinceRd <= sinceRd + 1;
  end

  p_turnaround_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && stateNext == ST_WPULSE) |-> (sinceRd >= TURN_CYC));

  p_ack_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack);

  p_lowpower_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && lowPower) |=> (state == ST_IDLE));

  p_no_start_in_ack_r9: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> (state == ST_IDLE));

endmodule

// File: rtl/sram_link_dpath.sv
`timescale 1ns/1ps
module sram_link_dpath
  import sram_link_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busDrive,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memSelN,
  output logic              memSelHi,
  output logic              memOutEnN,
  output logic              memWrEnN
);

  logic              selQ, oeQ, weQ, driveQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ   <= 1'b0;
      oeQ    <= 1'b0;
      weQ    <= 1'b0;
      driveQ <= 1'b0;
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      selQ   <= strb.sel;
      oeQ    <= strb.oe;
      weQ    <= strb.we;
      driveQ <= strb.drive;
      if (strb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strb.capture) rdataQ <= busIn;
    end
  end

  assign memSelN   = !selQ;
  assign memSelHi  = selQ;
  assign memOutEnN = !oeQ;
  assign memWrEnN  = !weQ;
  assign memAddr   = addrQ;
  assign busOut    = wdataQ;
  assign busDrive  = driveQ;
  assign rdata     = rdataQ;

  p_write_selected_r6: assert property (@(posedge clk) disable iff (!rstN)
    !memWrEnN |-> (!memSelN && memSelHi));

  p_oe_we_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    !memOutEnN |-> memWrEnN);

  p_drive_outputs_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    busDrive |-> (memOutEnN && !memSelN));

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!memSelN && $past(!memSelN)) |-> $stable(memAddr));

endmodule

// File: rtl/sram_link.sv
`timescale 1ns/1ps
module sram_link
  import sram_link_pkg::*;
#(
  parameter int SPEED_NS    = 55,
  parameter int CLK_NS      = 5,
  parameter int WE_PULSE_NS = SPEED_NS,
  parameter int WR_HOLD_NS  = CLK_NS,
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              lowPower,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memSelN,
  output logic              memSelHi,
  output logic              memOutEnN,
  output logic              memWrEnN,
  inout  wire  [DATA_W-1:0] memData
);

  localparam int ACC_CYC  = ceilCycles(SPEED_NS, CLK_NS);
  localparam int OE_RAW   = ceilCycles(gradeOeNs(SPEED_NS), CLK_NS);
  localparam int OE_CYC   = (OE_RAW > ACC_CYC) ? ACC_CYC : OE_RAW;
  localparam int SELF_CYC = ceilCycles(gradeSelFloatNs(SPEED_NS), CLK_NS);
  localparam int OEF_CYC  = ceilCycles(gradeOeFloatNs(SPEED_NS), CLK_NS);
  localparam int TURN_CYC = (SELF_CYC > OEF_CYC) ? SELF_CYC : OEF_CYC;
  localparam int WE_CYC   = ceilCycles(WE_PULSE_NS, CLK_NS);
  localparam int WH_CYC   = ceilCycles(WR_HOLD_NS, CLK_NS);

  strobe_t           strb;
  logic [DATA_W-1:0] busOut;
  logic              busDrive;

  sram_link_ctrl #(
    .ACC_CYC(ACC_CYC), .OE_CYC(OE_CYC), .TURN_CYC(TURN_CYC),
    .WE_CYC(WE_CYC), .WH_CYC(WH_CYC), .REC_CYC(ACC_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .lowPower(lowPower), .ack(ack), .strb(strb)
  );

  sram_link_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .busIn(memData), .busOut(busOut),
    .busDrive(busDrive), .rdata(rdata), .memAddr(memAddr),
    .memSelN(memSelN), .memSelHi(memSelHi), .memOutEnN(memOutEnN),
    .memWrEnN(memWrEnN)
  );

  assign memData = busDrive ? busOut : {DATA_W{1'bz}};

endmodule

// File: tb/sram_link_test.sv
`timescale 1ns/1ps
module sram_link_test;

  localparam int ACC  = 11;  // R4
  localparam int OEC  = 7;   // R4
  localparam int TURN = 5;   // R8
  localparam int WEC  = 11;  // R6
  localparam int WHC  = 1;   // R6
  localparam int REC  = 11;  // R9

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, lowPower = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        ack;
  logic [7:0]  rdata;
  logic [16:0] memAddr;
  logic        memSelN, memSelHi, memOutEnN, memWrEnN;
  wire  [7:0]  memData;

  always #2.5 clk = ~clk;

  sram_link uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .lowPower(lowPower),
    .ack(ack), .rdata(rdata), .memAddr(memAddr), .memSelN(memSelN),
    .memSelHi(memSelHi), .memOutEnN(memOutEnN), .memWrEnN(memWrEnN),
    .memData(memData)
  );

  // ---------------- memory model on the bus ----------------
  logic [7:0] ramArr [int];
  logic [7:0] ramOut;
  logic       ramDrive;

  function automatic logic [7:0] fillByte(input logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always_comb begin
    ramDrive = !memSelN && memSelHi && memWrEnN && !memOutEnN;
    ramOut   = ramArr.exists(int'(memAddr)) ? ramArr[int'(memAddr)] : fillByte(memAddr);
  end
  assign memData = ramDrive ? ramOut : 8'bz;

  always @(posedge memWrEnN)
    if (!memSelN && memSelHi) ramArr[int'(memAddr)] = memData;

  // ---------------- reference model ----------------
  typedef struct packed {
    logic selN, selHi, oeN, weN, drive, ackE, isRead;
    logic [16:0] addr;
    logic [7:0]  data;
  } snap_t;

  localparam snap_t IDLE_SNAP = '{selN:1'b1, selHi:1'b0, oeN:1'b1, weN:1'b1,
                                  drive:1'b0, ackE:1'b0, isRead:1'b0,
                                  addr:17'd0, data:8'd0};

  snap_t      q[$];
  snap_t      cur = IDLE_SNAP;
  logic [7:0] refMem [int];
  logic [7:0] expRdata = 8'h00;
  int         recLeft = 0, hizLeft = 0;

  function automatic logic [7:0] refRead(input logic [16:0] a);
    return refMem.exists(int'(a)) ? refMem[int'(a)] : fillByte(a);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete();
      cur = IDLE_SNAP; recLeft = 0; hizLeft = 0; expRdata = 8'h00;
    end else if (q.size() != 0) begin
      cur = q.pop_front();
      if (cur.ackE && cur.isRead) begin
        hizLeft  = TURN;
        expRdata = refRead(cur.addr);
      end
    end else begin
      automatic logic take = reqValid && !lowPower && recLeft == 0 && !cur.ackE &&
                             (!reqWrite || hizLeft == 0);
      if (lowPower) recLeft = REC; else if (recLeft > 0) recLeft--;
      if (hizLeft > 0) hizLeft--;
      if (take) begin
        automatic snap_t s = IDLE_SNAP;
        s.addr = reqAddr; s.data = reqWdata;
        s.selN = 1'b0; s.selHi = 1'b1;
        if (!reqWrite) begin
          for (int i = 0; i < ACC; i++) begin
            s.oeN = !(i >= ACC - OEC);
            q.push_back(s);
          end
        end else begin
          s.drive = 1'b1; s.weN = 1'b0;
          for (int i = 0; i < WEC; i++) q.push_back(s);
          s.weN = 1'b1;
          for (int i = 0; i < WHC; i++) q.push_back(s);
          refMem[int'(reqAddr)] = reqWdata;
        end
        s = IDLE_SNAP; s.ackE = 1'b1; s.isRead = !reqWrite; s.addr = reqAddr;
        q.push_back(s);
        cur = q.pop_front();
      end else begin
        cur = IDLE_SNAP;
      end
    end
  end

  // ---------------- comparison every cycle ----------------
  int vectors = 0, miscompares = 0;
  logic runDone = 1'b0;

  always @(negedge clk) begin
    automatic bit bad = 1'b0;
    vectors++;
    if (memSelN !== cur.selN || memSelHi !== cur.selHi) begin
      bad = 1'b1;
      $display("FAIL R2/R1 selects: actual %b%b expected %b%b @%0t",
               memSelN, memSelHi, cur.selN, cur.selHi, $time);
    end
    if (memOutEnN !== cur.oeN) begin
      bad = 1'b1;
      $display("FAIL R4 output enable: actual %b expected %b @%0t", memOutEnN, cur.oeN, $time);
    end
    if (memWrEnN !== cur.weN) begin
      bad = 1'b1;
      $display("FAIL R6 write enable: actual %b expected %b @%0t", memWrEnN, cur.weN, $time);
    end
    if (ack !== cur.ackE) begin
      bad = 1'b1;
      $display("FAIL R9 ack: actual %b expected %b @%0t", ack, cur.ackE, $time);
    end
    if (!cur.selN && memAddr !== cur.addr) begin
      bad = 1'b1;
      $display("FAIL R3 address: actual %h expected %h @%0t", memAddr, cur.addr, $time);
    end
    if (cur.drive && memData !== cur.data) begin
      bad = 1'b1;
      $display("FAIL R7 write data: actual %h expected %h @%0t", memData, cur.data, $time);
    end
    if (rdata !== expRdata) begin
      bad = 1'b1;
      $display("FAIL R5/R10 rdata: actual %h expected %h @%0t", rdata, expRdata, $time);
    end
    if (bad) miscompares++;
  end

  // ---------------- stimulus ----------------
  task automatic access(input logic wr, input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    while (!ack) @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [16:0] lf = 17'h1ACE1;
    idle(4);                                   // R1: reset values checked
    rstN = 1'b1;
    idle(3);                                   // R1, R2
    access(1'b1, 17'h00000, 8'h00);            // R6, R7 at low end
    access(1'b1, 17'h1FFFF, 8'hFF);            // R6, R7 at high end
    access(1'b1, 17'h0A5A5, 8'hA5);
    access(1'b0, 17'h1FFFF, 8'h00);            // R4, R5, R10
    access(1'b0, 17'h00000, 8'h00);            // R10
    access(1'b0, 17'h0A5A5, 8'h00);
    access(1'b0, 17'h12345, 8'h00);            // R10 unwritten fill
    access(1'b1, 17'h12345, 8'h3C);            // R8: write straight after read
    access(1'b0, 17'h12345, 8'h00);            // write then read
    idle(2);
    lowPower = 1'b1;                           // R9: standby hold
    idle(3);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 17'h0A5A5;
    idle(15);
    lowPower = 1'b0;                           // R9: recovery then start
    while (!ack) @(negedge clk);
    reqValid = 1'b0;
    for (int n = 0; n < 40; n++) begin         // mixed traffic, R3-R10
      lf = {lf[15:0], lf[16] ^ lf[13]};
      access(lf[0], lf, lf[8:1] ^ 8'h96);
      idle(int'(lf[3:2]));
    end
    idle(5);
    runDone = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!runDone) begin
      miscompares++;
      $display("FAIL R9 watchdog: actual no completion expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule